// File: doc/BRIEF.md
# Processor bus cycle statistics unit

This block sits beside a pipelined processor model and counts what happens on each bus cycle. A single qualifying strobe, `cyc_valid`, marks one elapsed bus cycle. Every event strobe is taken into account only in a cycle where `cyc_valid` is high. With those strobes the block keeps seven saturating counters:

- total cycles
- instruction-bus idle (internal) cycles
- data-bus idle cycles
- dependency interlock cycles
- executed instructions
- loads
- stores

When `calc_req` is pulsed, the block copies all seven counters into a snapshot. One shared bit-serial divider then derives six fixed-point percentages from that snapshot:

- instruction-bus utilization
- data-bus utilization
- interlock loss
- the instruction share of instructions plus loads plus stores
- the load share, computed the same way
- the store share, computed the same way

When all six are ready, `calc_done` goes high. Counting goes on while the divider runs. A synchronous `clr` empties everything.

Top module: `bus_cycle_stats`

## Requirements
- R1: After reset, all counters and all six percentage outputs read zero and `calc_done` is low.
- R2: `cnt_total` and the event counters (`cnt_instr`, `cnt_load`, `cnt_store`, `cnt_interlock`) rise by one on each clock edge where `cyc_valid` and their strobe are high. Any strobe seen while `cyc_valid` is low has no effect.
- R3: `cnt_ibus_idle` / `cnt_dbus_idle` count the valid cycles with `ibus_idle` / `dbus_idle` high, so neither one exceeds `cnt_total`.
- R4: A counter that has reached all ones (2^CNT_W−1) holds that value instead of wrapping.
- R5: `clr` zeroes every counter, every percentage and `calc_done` on the next edge. It takes priority over counting and over a request.
- R6: Utilization of each bus is floor((total − idle) × 100 × 2^FRAC_W / total). The result carries FRAC_W fraction bits, so with the default of 8 the value 25600 means 100 %.
- R7: `pct_dep_loss` = floor(interlock × 100 × 2^FRAC_W / total).
- R8: The instruction, load and store shares are each floor(count × 100 × 2^FRAC_W / (instr + load + store)).
- R9: A percentage whose denominator is zero is 0.
- R10: A request made while no computation is running clears `calc_done` on the next edge. `calc_done` goes high within 6 × (DVD_W + 2) cycles and stays high until the next accepted request or `clr`.
- R11: The percentages are taken from the counter values at the request edge. Events counted while the divider runs do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters and results |
| cyc_valid | input | 1 | One bus cycle elapsed; qualifies all strobes |
| ibus_idle | input | 1 | Instruction bus idle this cycle |
| dbus_idle | input | 1 | Data bus idle this cycle |
| ev_instr | input | 1 | Instruction executed |
| ev_load | input | 1 | Load operation |
| ev_store | input | 1 | Store operation |
| ev_interlock | input | 1 | Dependency interlock cycle |
| calc_req | input | 1 | Start percentage computation |
| cnt_instr | output | CNT_W | Instruction count |
| cnt_load | output | CNT_W | Load count |
| cnt_store | output | CNT_W | Store count |
| cnt_interlock | output | CNT_W | Interlock cycle count |
| cnt_total | output | CNT_W | Total cycle count |
| cnt_ibus_idle | output | CNT_W | Instruction-bus idle cycles |
| cnt_dbus_idle | output | CNT_W | Data-bus idle cycles |
| pct_ibus_util | output | 7+FRAC_W | Instruction-bus utilization |
| pct_dbus_util | output | 7+FRAC_W | Data-bus utilization |
| pct_dep_loss | output | 7+FRAC_W | Interlock loss |
| pct_instr | output | 7+FRAC_W | Instruction share |
| pct_load | output | 7+FRAC_W | Load share |
| pct_store | output | 7+FRAC_W | Store share |
| calc_done | output | 1 | Percentages valid |

## Verification
A strobe driven in one cycle shows up in the counters after exactly one clock edge, so the bench drives its inputs on the falling edge and reads the counters on the following falling edge. `calc_done` falls one edge after an accepted request, and the bench checks it in that exact window. The divider's completion time depends on the denominators, so the bench polls `calc_done` against the R10 bound instead of a fixed cycle. It checks the percentages only once `calc_done` is high, and keeps feeding events during the wait so that R11 is exercised.

// File: rtl/bus_stats_pkg.sv
// Shared indices for the statistics unit.
// Assumes seven counters and six computed percentages.
package bus_stats_pkg;
    localparam int NUM_CNT = 7;
    localparam int NUM_PCT = 6;

    typedef enum logic [2:0] {
        C_TOTAL = 3'd0,
        C_IIDLE = 3'd1,
        C_DIDLE = 3'd2,
        C_ILOCK = 3'd3,
        C_INSTR = 3'd4,
        C_LOAD  = 3'd5,
        C_STORE = 3'd6
    } cnt_idx_e;

    typedef enum logic [2:0] {
        P_IUTIL = 3'd0,
        P_DUTIL = 3'd1,
        P_LOSS  = 3'd2,
        P_INSTR = 3'd3,
        P_LOAD  = 3'd4,
        P_STORE = 3'd5
    } pct_idx_e;
endpackage

// File: rtl/stat_sat_counter.sv
// Saturating event counter with synchronous clear.
// Assumes inc is already qualified by the cycle strobe.
module stat_sat_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAX = '1;

    // Count up, stopping at all ones; clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count <= '0;
        else if (inc && count != MAX)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/stat_pct_divider.sv
// Bit-serial restoring divider producing floor(num*100*2^FRAC_W/den).
// Assumes num <= den so the quotient fits 7+FRAC_W bits; den==0 gives 0.
module stat_pct_divider #(
    parameter int NUM_W  = 66,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  logic [NUM_W-1:0]  num,
    input  logic [NUM_W-1:0]  den,
    output logic [6+FRAC_W:0] quo,
    output logic              res_valid
);
    localparam int DVD_W = NUM_W + 7 + FRAC_W;
    localparam int Q_W   = 7 + FRAC_W;
    localparam int CW    = $clog2(DVD_W + 1);

    logic [DVD_W-1:0] dvd;
    logic [NUM_W-1:0] rem;
    logic [NUM_W:0]   rem_sh;
    logic [NUM_W-1:0] rem_nxt;
    logic             qbit;
    logic [CW-1:0]    cnt;
    logic             run;

    // One long-division step: bring down a bit, subtract when it fits.
    always_comb begin
        rem_sh  = {rem, dvd[DVD_W-1]};
        qbit    = rem_sh >= {1'b0, den};
        rem_nxt = qbit ? NUM_W'(rem_sh - {1'b0, den}) : rem_sh[NUM_W-1:0];
    end

    // Sequence the steps and flag the result for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            dvd <= '0; rem <= '0; quo <= '0; cnt <= '0;
            run <= 1'b0; res_valid <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (start) begin
                quo <= '0;
                if (den == '0) begin
                    res_valid <= 1'b1;
                    run       <= 1'b0;
                end else begin
                    dvd <= (DVD_W'(num) * DVD_W'(100)) << FRAC_W;
                    rem <= '0;
                    cnt <= CW'(DVD_W);
                    run <= 1'b1;
                end
            end else if (run) begin
                rem <= rem_nxt;
                quo <= {quo[Q_W-2:0], qbit};
                dvd <= dvd << 1;
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run       <= 1'b0;
                    res_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bus_cycle_stats.sv
// Top: seven saturating counters plus a snapshot-and-divide sequencer
// that fills six percentage registers. Assumes all strobes are
// synchronous to clk and qualified by cyc_valid.
module bus_cycle_stats
    import bus_stats_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cyc_valid,
    input  logic              ibus_idle,
    input  logic              dbus_idle,
    input  logic              ev_instr,
    input  logic              ev_load,
    input  logic              ev_store,
    input  logic              ev_interlock,
    input  logic              calc_req,
    output logic [CNT_W-1:0]  cnt_instr,
    output logic [CNT_W-1:0]  cnt_load,
    output logic [CNT_W-1:0]  cnt_store,
    output logic [CNT_W-1:0]  cnt_interlock,
    output logic [CNT_W-1:0]  cnt_total,
    output logic [CNT_W-1:0]  cnt_ibus_idle,
    output logic [CNT_W-1:0]  cnt_dbus_idle,
    output logic [6+FRAC_W:0] pct_ibus_util,
    output logic [6+FRAC_W:0] pct_dbus_util,
    output logic [6+FRAC_W:0] pct_dep_loss,
    output logic [6+FRAC_W:0] pct_instr,
    output logic [6+FRAC_W:0] pct_load,
    output logic [6+FRAC_W:0] pct_store,
    output logic              calc_done
);
    localparam int NUM_W = CNT_W + 2;
    localparam int PCT_W = 7 + FRAC_W;

    logic [NUM_CNT-1:0] inc;
    logic [CNT_W-1:0]   cnt  [NUM_CNT];
    logic [CNT_W-1:0]   snap [NUM_CNT];
    logic [PCT_W-1:0]   pct  [NUM_PCT];
    logic [2:0]         idx;
    logic               busy, start_q;
    logic [NUM_W-1:0]   d_num, d_den, share_den;
    logic [PCT_W-1:0]   d_quo;
    logic               d_valid;

    // Qualify each strobe with the cycle marker.
    always_comb begin
        inc          = '0;
        inc[C_TOTAL] = cyc_valid;
        inc[C_IIDLE] = cyc_valid & ibus_idle;
        inc[C_DIDLE] = cyc_valid & dbus_idle;
        inc[C_ILOCK] = cyc_valid & ev_interlock;
        inc[C_INSTR] = cyc_valid & ev_instr;
        inc[C_LOAD]  = cyc_valid & ev_load;
        inc[C_STORE] = cyc_valid & ev_store;
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        stat_sat_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc[g]), .count(cnt[g])
        );
    end

    // Pick numerator and denominator for the current operation.
    always_comb begin
        share_den = NUM_W'(snap[C_INSTR]) + NUM_W'(snap[C_LOAD]) + NUM_W'(snap[C_STORE]);
        d_den     = NUM_W'(snap[C_TOTAL]);
        d_num     = '0;
        case (idx)
            P_IUTIL: d_num = NUM_W'(snap[C_TOTAL] - snap[C_IIDLE]);
            P_DUTIL: d_num = NUM_W'(snap[C_TOTAL] - snap[C_DIDLE]);
            P_LOSS:  d_num = NUM_W'(snap[C_ILOCK]);
            P_INSTR: begin d_num = NUM_W'(snap[C_INSTR]); d_den = share_den; end
            P_LOAD:  begin d_num = NUM_W'(snap[C_LOAD]);  d_den = share_den; end
            default: begin d_num = NUM_W'(snap[C_STORE]); d_den = share_den; end
        endcase
    end

    stat_pct_divider #(.NUM_W(NUM_W), .FRAC_W(FRAC_W)) u_div (
        .clk(clk), .rst_n(rst_n), .abort(clr), .start(start_q),
        .num(d_num), .den(d_den), .quo(d_quo), .res_valid(d_valid)
    );

    // Snapshot on request, then walk the six divisions in order.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy <= 1'b0; start_q <= 1'b0; calc_done <= 1'b0; idx <= '0;
            for (int i = 0; i < NUM_PCT; i++) pct[i] <= '0;
            for (int i = 0; i < NUM_CNT; i++) snap[i] <= '0;
        end else begin
            start_q <= 1'b0;
            if (calc_req && !busy) begin
                for (int i = 0; i < NUM_CNT; i++) snap[i] <= cnt[i];
                busy      <= 1'b1;
                idx       <= '0;
                start_q   <= 1'b1;
                calc_done <= 1'b0;
            end else if (busy && d_valid) begin
                pct[idx] <= d_quo;
                if (idx == 3'(NUM_PCT - 1)) begin
                    busy      <= 1'b0;
                    calc_done <= 1'b1;
                end else begin
                    idx     <= idx + 1'b1;
                    start_q <= 1'b1;
                end
            end
        end
    end

    assign cnt_total     = cnt[C_TOTAL];
    assign cnt_ibus_idle = cnt[C_IIDLE];
    assign cnt_dbus_idle = cnt[C_DIDLE];
    assign cnt_interlock = cnt[C_ILOCK];
    assign cnt_instr     = cnt[C_INSTR];
    assign cnt_load      = cnt[C_LOAD];
    assign cnt_store     = cnt[C_STORE];
    assign pct_ibus_util = pct[P_IUTIL];
    assign pct_dbus_util = pct[P_DUTIL];
    assign pct_dep_loss  = pct[P_LOSS];
    assign pct_instr     = pct[P_INSTR];
    assign pct_load      = pct[P_LOAD];
    assign pct_store     = pct[P_STORE];
endmodule

// File: rtl/bus_cycle_stats_chk.sv
// Property checker for bus_cycle_stats, bound to every instance.
// Assumes synchronous active-low reset.
module bus_cycle_stats_chk #(
    parameter int CNT_W  = 64,
    parameter int FRAC_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              cyc_valid,
    input logic              calc_req,
    input logic [CNT_W-1:0]  cnt_total,
    input logic [CNT_W-1:0]  cnt_ibus_idle,
    input logic [CNT_W-1:0]  cnt_dbus_idle,
    input logic [6+FRAC_W:0] pct_ibus_util,
    input logic              calc_done
);
    localparam logic [CNT_W-1:0]  MAX  = '1;
    localparam logic [6+FRAC_W:0] FULL = (7+FRAC_W)'(100) << FRAC_W;

    p_total_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cyc_valid && cnt_total != MAX) |=> (cnt_total - $past(cnt_total)) == CNT_W'(1));

    p_idle_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_ibus_idle <= cnt_total) && (cnt_dbus_idle <= cnt_total));

    p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_total == MAX) |=> cnt_total == MAX);

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_total == '0) && !calc_done);

    p_pct_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        calc_done |-> pct_ibus_util <= FULL);

    p_done_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_req && calc_done && !clr) |=> !calc_done);
endmodule

bind bus_cycle_stats bus_cycle_stats_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cyc_valid(cyc_valid), .calc_req(calc_req),
    .cnt_total(cnt_total), .cnt_ibus_idle(cnt_ibus_idle), .cnt_dbus_idle(cnt_dbus_idle),
    .pct_ibus_util(pct_ibus_util), .calc_done(calc_done)
);

// File: tb/bus_cycle_stats_test.sv
// Vector-driven bench for bus_cycle_stats, narrow counters for saturation.
module bus_cycle_stats_test;
    localparam int CW = 8;
    localparam int FW = 8;
    localparam int PW = 7 + FW;
    localparam int WAIT_MAX = 6 * ((CW + 2 + 7 + FW) + 2) + 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 0, cyc_valid = 0, ibus_idle = 0, dbus_idle = 0;
    logic ev_instr = 0, ev_load = 0, ev_store = 0, ev_interlock = 0, calc_req = 0;
    logic [CW-1:0] c_instr, c_load, c_store, c_ilock, c_total, c_iidle, c_didle;
    logic [PW-1:0] p_iu, p_du, p_loss, p_in, p_ld, p_st;
    logic done;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    bus_cycle_stats #(.CNT_W(CW), .FRAC_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cyc_valid(cyc_valid),
        .ibus_idle(ibus_idle), .dbus_idle(dbus_idle), .ev_instr(ev_instr),
        .ev_load(ev_load), .ev_store(ev_store), .ev_interlock(ev_interlock),
        .calc_req(calc_req), .cnt_instr(c_instr), .cnt_load(c_load),
        .cnt_store(c_store), .cnt_interlock(c_ilock), .cnt_total(c_total),
        .cnt_ibus_idle(c_iidle), .cnt_dbus_idle(c_didle),
        .pct_ibus_util(p_iu), .pct_dbus_util(p_du), .pct_dep_loss(p_loss),
        .pct_instr(p_in), .pct_load(p_ld), .pct_store(p_st), .calc_done(done)
    );

    // Fields: total, instr, load, store, interlock, ibus idle, dbus idle.
    localparam logic [111:0] VEC [5] = '{
        {16'd0,   16'd0,  16'd0,   16'd0,  16'd0,  16'd0,  16'd0},
        {16'd10,  16'd6,  16'd3,   16'd1,  16'd2,  16'd4,  16'd7},
        {16'd100, 16'd50, 16'd30,  16'd20, 16'd0,  16'd0,  16'd100},
        {16'd37,  16'd37, 16'd0,   16'd0,  16'd37, 16'd37, 16'd0},
        {16'd200, 16'd13, 16'd200, 16'd7,  16'd99, 16'd1,  16'd150}
    };
    localparam int EXTRA = 3;

    function automatic longint pct_of(longint num, longint den);
        return (den == 0) ? 0 : (num * 100 * (longint'(1) << FW)) / den;
    endfunction

    function automatic longint satv(longint v);
        return (v > 255) ? 255 : v;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(bit v, bit ii, bit di, bit i, bit l, bit s, bit k);
        cyc_valid = v; ibus_idle = ii; dbus_idle = di;
        ev_instr = i; ev_load = l; ev_store = s; ev_interlock = k;
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr = 1; @(negedge clk); clr = 0;
    endtask

    task automatic run_calc(int extra);
        calc_req = 1; @(negedge clk); calc_req = 0;
        chk("R10 done cleared by request", done, 0);
        for (int w = 0; w < WAIT_MAX && !done; w++) begin
            if (w < extra) drive(1, 1, 1, 1, 1, 1, 1);
            else drive(0, 0, 0, 0, 0, 0, 0);
        end
        chk("R10 done within bound", done, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; @(negedge clk);
        // R1 reset state
        chk("R1 total", c_total, 0); chk("R1 instr", c_instr, 0);
        chk("R1 pct", p_iu, 0); chk("R1 done", done, 0);

        foreach (VEC[v]) begin
            longint t, ni, nl, ns, nk, ii, di, sd;
            {t, ni, nl, ns, nk, ii, di} = {48'd0, VEC[v][111:96], 48'd0, VEC[v][95:80],
                48'd0, VEC[v][79:64], 48'd0, VEC[v][63:48], 48'd0, VEC[v][47:32],
                48'd0, VEC[v][31:16], 48'd0, VEC[v][15:0]};
            pulse_clr();
            for (int c = 0; c < t; c++) begin
                drive(0, 1, 1, 1, 1, 1, 1);   // ignored: no cycle marker
                drive(1, c < ii, c < di, c < ni, c < nl, c < ns, c < nk);
            end
            drive(0, 0, 0, 0, 0, 0, 0);
            chk("R2 total", c_total, t);      chk("R2 instr", c_instr, ni);
            chk("R2 load", c_load, nl);       chk("R2 store", c_store, ns);
            chk("R2 interlock", c_ilock, nk);
            chk("R3 ibus idle", c_iidle, ii); chk("R3 dbus idle", c_didle, di);
            run_calc(EXTRA);
            sd = ni + nl + ns;
            chk("R6 ibus util", p_iu, pct_of(t - ii, t));
            chk("R6 dbus util", p_du, pct_of(t - di, t));
            chk("R7 dep loss", p_loss, pct_of(nk, t));
            chk("R8 instr share", p_in, pct_of(ni, sd));
            chk("R8 load share", p_ld, pct_of(nl, sd));
            chk("R8 store share", p_st, pct_of(ns, sd));
            if (t == 0) chk("R9 zero denominator", p_iu, 0);
            chk("R11 counting continued", c_total, satv(t + EXTRA));
        end

        // R4 saturation at 255 for every counter
        pulse_clr();
        for (int c = 0; c < 300; c++) drive(1, 1, 1, 1, 1, 1, 1);
        drive(0, 0, 0, 0, 0, 0, 0);
        chk("R4 total held", c_total, 255); chk("R4 store held", c_store, 255);
        run_calc(0);
        chk("R4 ibus util", p_iu, 0);
        chk("R4 instr share", p_in, pct_of(255, 765));
        chk("R10 done held", done, 1);
        drive(0, 0, 0, 0, 0, 0, 0);
        chk("R10 done still held", done, 1);

        // R5 clear beats a simultaneous cycle and request
        clr = 1; calc_req = 1;
        drive(1, 1, 1, 1, 1, 1, 1);
        clr = 0; calc_req = 0;
        chk("R5 total cleared", c_total, 0); chk("R5 idle cleared", c_iidle, 0);
        chk("R5 pct cleared", p_in, 0);     chk("R5 done cleared", done, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule